// File: doc/BRIEF.md
# Data-Space Address Generator and Decoder

This block turns one data-memory request from an 8-bit core into an effective address in a single linear data space of 1120 byte locations. It routes the access to one of three targets: the 32 working registers, the 64 I/O registers, or 1024 bytes of internal SRAM. The address comes from one of five modes. Direct mode takes a 16-bit address. The other four modes use a pointer: plain, pointer plus an unsigned displacement, decrement-then-use, and use-then-increment.

The three 16-bit pointers come in from the upper working registers. Pointer X is R27:R26, Y is R29:R28 and Z is R31:R30, with the odd register holding the high byte. Any updated pointer value goes back out on a writeback port.

Register and I/O accesses finish in the cycle they are requested. An SRAM access takes two cycles:
- In the first cycle the block computes the address and raises `busy`, so the core stalls.
- In the second cycle the SRAM is enabled and the data moves.

Top module: `dspace_agu`

## Requirements
- R1: The effective address (EA) selects the target. EA 0x0000–0x001F is register `rf_idx` = EA. EA 0x0020–0x005F is I/O `io_idx` = EA−0x20. EA 0x0060–0x045F is SRAM `sram_addr` = EA−0x60. Read data comes from the selected target, and at most one write enable is high at a time.
- R2: Mode code 0 is direct: EA = `dir_addr`, and the pointers are never written back.
- R3: Mode code 1 is indirect: EA = the selected pointer, with no writeback. `ptr_sel` codes are 0 for X, 1 for Y and 2 for Z.
- R4: Mode code 2 adds `disp` (0–63, unsigned) to Y or Z, wrapping modulo 2^16, and never writes the pointer back. Using X as the base is illegal.
- R5: Mode code 3 is pre-decrement: EA = pointer−1 (mod 2^16), and pointer−1 is written back.
- R6: Mode code 4 is post-increment: EA = pointer, and pointer+1 (mod 2^16) is written back.
- R7: A register or I/O access completes in its request cycle. In that cycle `done`=1, `busy`=0, and `rf_we`/`io_we` follow `wr`.
- R8: An SRAM access holds `busy`=1 and `done`=0 in its first cycle. In the next cycle `sram_en`=1, `sram_we`=`wr`, `done`=1 and `rdata`=`sram_rdata`.
- R9: A pointer writeback (`ptr_we`, `ptr_wsel`, `ptr_wdata`) happens exactly once per pre-decrement or post-increment access, in its completion cycle.
- R10: An EA of 0x0460 or above completes in one cycle with `range_err`=1. It writes nothing and reads 0x00, but the pointer writeback of R5/R6 still takes place.
- R11: The following are illegal: mode codes 5–7, `ptr_sel`=3 in a pointer mode, and mode 2 with X. An illegal access completes in one cycle with `mode_err`=1, no write, no writeback and `rdata`=0x00.
- R12: A `req` present in the completion cycle of an SRAM access is ignored. It causes no write, no error and no `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request |
| wr | input | 1 | 1 = write, 0 = read |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Pointer select (0 X, 1 Y, 2 Z) |
| disp | input | 6 | Unsigned displacement |
| dir_addr | input | 16 | Direct address |
| wdata | input | 8 | Write data |
| ptr_x | input | 16 | Pointer X (R27:R26) |
| ptr_y | input | 16 | Pointer Y (R29:R28) |
| ptr_z | input | 16 | Pointer Z (R31:R30) |
| busy | output | 1 | Stall: first cycle of an SRAM access |
| done | output | 1 | Access completes this cycle |
| ea | output | 16 | Effective address of the current access |
| range_err | output | 1 | EA beyond the data space |
| mode_err | output | 1 | Illegal mode or pointer |
| ptr_we | output | 1 | Pointer writeback strobe |
| ptr_wsel | output | 2 | Pointer being written back |
| ptr_wdata | output | 16 | New pointer value |
| rf_we | output | 1 | Working-register write enable |
| rf_idx | output | 5 | Working-register index |
| rf_rdata | input | 8 | Working-register read data |
| io_we | output | 1 | I/O register write enable |
| io_idx | output | 6 | I/O register index |
| io_rdata | input | 8 | I/O register read data |
| mem_wdata | output | 8 | Write data to the selected target |
| sram_en | output | 1 | SRAM access (second cycle) |
| sram_we | output | 1 | SRAM write |
| sram_addr | output | 10 | SRAM byte offset |
| sram_rdata | input | 8 | SRAM read data |
| rdata | output | 8 | Read data returned to the core |

## Verification
Two things fall in the second cycle of a pre-decrement or post-increment SRAM access: the pointer writeback and the SRAM data transfer. A fresh request can also arrive in that same cycle. The bench provokes all of these by walking pointers across the I/O/SRAM and SRAM/out-of-range boundaries, and by holding `req` high with a register write during a completion cycle. It judges them by checking that `ptr_we` is low in the stall cycle and high with the right value in the data cycle, that the SRAM moves the stored data, and that the overlapping request writes nothing.

// File: rtl/dspace_agu.sv
module dspace_agu #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int DISP_W = 6,
  parameter int RF_N   = 32,
  parameter int IO_N   = 64,
  parameter int SRAM_N = 1024
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic                    wr,
  input  logic [2:0]              mode,
  input  logic [1:0]              ptr_sel,
  input  logic [DISP_W-1:0]       disp,
  input  logic [AW-1:0]           dir_addr,
  input  logic [DW-1:0]           wdata,
  input  logic [AW-1:0]           ptr_x,
  input  logic [AW-1:0]           ptr_y,
  input  logic [AW-1:0]           ptr_z,
  output logic                    busy,
  output logic                    done,
  output logic [AW-1:0]           ea,
  output logic                    range_err,
  output logic                    mode_err,
  output logic                    ptr_we,
  output logic [1:0]              ptr_wsel,
  output logic [AW-1:0]           ptr_wdata,
  output logic                    rf_we,
  output logic [$clog2(RF_N)-1:0] rf_idx,
  input  logic [DW-1:0]           rf_rdata,
  output logic                    io_we,
  output logic [$clog2(IO_N)-1:0] io_idx,
  input  logic [DW-1:0]           io_rdata,
  output logic [DW-1:0]           mem_wdata,
  output logic                    sram_en,
  output logic                    sram_we,
  output logic [$clog2(SRAM_N)-1:0] sram_addr,
  input  logic [DW-1:0]           sram_rdata,
  output logic [DW-1:0]           rdata
);
  localparam int IO_BASE   = RF_N;
  localparam int SRAM_BASE = RF_N + IO_N;
  localparam int SPACE_END = SRAM_BASE + SRAM_N;
  localparam int RFI_W     = $clog2(RF_N);
  localparam int IOI_W     = $clog2(IO_N);
  localparam int SA_W      = $clog2(SRAM_N);
  localparam logic [2:0] M_DIR = 3'd0, M_IND = 3'd1, M_DSP = 3'd2, M_PRE = 3'd3, M_POST = 3'd4;

  logic          ph2, go, bad, upd, legal;
  logic          in_rf, in_io, in_sr, oor;
  logic [AW-1:0] base, ea_c, new_p;
  logic [AW-1:0] ea_q, wval_q;
  logic [1:0]    wsel_q;
  logic          wr_q, wb_q;
  logic [DW-1:0] wd_q;

  assign go = req && !ph2;

  always_comb begin
    case (ptr_sel)
      2'd0:    base = ptr_x;
      2'd1:    base = ptr_y;
      2'd2:    base = ptr_z;
      default: base = '0;
    endcase
  end

  assign bad = (mode > M_POST) ||
               (mode != M_DIR && ptr_sel == 2'd3) ||
               (mode == M_DSP && ptr_sel == 2'd0);

  always_comb begin
    case (mode)
      M_DIR:   ea_c = dir_addr;
      M_DSP:   ea_c = base + AW'(disp);
      M_PRE:   ea_c = base - AW'(1);
      default: ea_c = base;
    endcase
  end

  assign upd   = (mode == M_PRE || mode == M_POST) && !bad;
  assign new_p = (mode == M_PRE) ? base - AW'(1) : base + AW'(1);

  assign in_rf = ea_c < AW'(IO_BASE);
  assign in_io = !in_rf && ea_c < AW'(SRAM_BASE);
  assign in_sr = !in_rf && !in_io && ea_c < AW'(SPACE_END);
  assign oor   = ea_c >= AW'(SPACE_END);

  assign legal     = go && !bad;
  assign busy      = legal && in_sr;
  assign done      = (go && !busy) || ph2;
  assign ea        = ph2 ? ea_q : ea_c;
  assign range_err = legal && oor;
  assign mode_err  = go && bad;

  assign ptr_we    = ph2 ? wb_q : (legal && !in_sr && upd);
  assign ptr_wsel  = ph2 ? wsel_q : ptr_sel;
  assign ptr_wdata = ph2 ? wval_q : new_p;

  assign rf_we     = legal && in_rf && wr;
  assign io_we     = legal && in_io && wr;
  assign rf_idx    = ea_c[RFI_W-1:0];
  assign io_idx    = IOI_W'(ea_c - AW'(IO_BASE));
  assign mem_wdata = ph2 ? wd_q : wdata;

  assign sram_en   = ph2;
  assign sram_we   = ph2 && wr_q;
  assign sram_addr = SA_W'(ea_q - AW'(SRAM_BASE));

  always_comb begin
    if (ph2)                  rdata = sram_rdata;
    else if (legal && in_rf)  rdata = rf_rdata;
    else if (legal && in_io)  rdata = io_rdata;
    else                      rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph2    <= 1'b0;
      ea_q   <= '0;
      wr_q   <= 1'b0;
      wd_q   <= '0;
      wb_q   <= 1'b0;
      wsel_q <= '0;
      wval_q <= '0;
    end else begin
      ph2 <= busy;
      if (busy) begin
        ea_q   <= ea_c;
        wr_q   <= wr;
        wd_q   <= wdata;
        wb_q   <= upd;
        wsel_q <= ptr_sel;
        wval_q <= new_p;
      end
    end
  end

  p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, io_we, sram_we}));
  p_sram_second_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (sram_en && done && !busy));
  p_wb_only_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |-> (done && !busy));
  p_disp_no_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && mode == M_DSP) |-> !ptr_we);
  p_oor_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> (!rf_we && !io_we && !sram_en && rdata == '0 && done));
  p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (!ptr_we && !rf_we && !io_we && !busy && rdata == '0));
  p_overlap_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sram_en |-> (!busy && !rf_we && !io_we && !range_err && !mode_err));
endmodule

// File: tb/dspace_agu_bench.sv
module dspace_agu_bench;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, req = 0, wr = 0;
  logic [2:0] mode = 0;
  logic [1:0] ptr_sel = 0;
  logic [5:0] disp = 0;
  logic [15:0] dir_addr = 0, ptr_x = 0, ptr_y = 0, ptr_z = 0;
  logic [7:0] wdata = 0;
  logic busy, done, range_err, mode_err, ptr_we, rf_we, io_we, sram_en, sram_we;
  logic [15:0] ea, ptr_wdata;
  logic [1:0] ptr_wsel;
  logic [4:0] rf_idx;
  logic [5:0] io_idx;
  logic [9:0] sram_addr;
  logic [7:0] rf_rdata, io_rdata, sram_rdata, mem_wdata, rdata;
  logic [7:0] mem [1024];
  logic [7:0] ref_mem [1024];
  int n_chk = 0, n_bad = 0;

  dspace_agu u_dspace_agu (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .mode(mode), .ptr_sel(ptr_sel),
    .disp(disp), .dir_addr(dir_addr), .wdata(wdata), .ptr_x(ptr_x), .ptr_y(ptr_y),
    .ptr_z(ptr_z), .busy(busy), .done(done), .ea(ea), .range_err(range_err),
    .mode_err(mode_err), .ptr_we(ptr_we), .ptr_wsel(ptr_wsel), .ptr_wdata(ptr_wdata),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_rdata(rf_rdata), .io_we(io_we), .io_idx(io_idx),
    .io_rdata(io_rdata), .mem_wdata(mem_wdata), .sram_en(sram_en), .sram_we(sram_we),
    .sram_addr(sram_addr), .sram_rdata(sram_rdata), .rdata(rdata));

  always #(PERIOD/2) clk = ~clk;

  assign rf_rdata   = {3'b0, rf_idx} ^ 8'h5A;
  assign io_rdata   = {2'b0, io_idx} + 8'h40;
  assign sram_rdata = mem[sram_addr];
  always @(posedge clk) if (sram_en && sram_we) mem[sram_addr] <= mem_wdata;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(input int m, input int s, input int d, input int da,
                        input bit w, input logic [7:0] wd, input bit hold);
    int b, e, nv, reg_n;
    bit bd, up;
    string tg;
    b  = (s == 0) ? ptr_x : (s == 1) ? ptr_y : (s == 2) ? ptr_z : 0;
    bd = (m > 4) || (m != 0 && s == 3) || (m == 2 && s == 0);
    up = (m == 3 || m == 4) && !bd;
    nv = (m == 3) ? ((b - 1) & 16'hFFFF) : ((b + 1) & 16'hFFFF);
    case (m)
      0: begin e = da; tg = "R2"; end
      1: begin e = b; tg = "R3"; end
      2: begin e = (b + d) & 16'hFFFF; tg = "R4"; end
      3: begin e = (b - 1) & 16'hFFFF; tg = "R5"; end
      default: begin e = b; tg = "R6"; end
    endcase
    reg_n = (e < 32) ? 0 : (e < 96) ? 1 : (e < 1120) ? 2 : 3;
    @(negedge clk);
    req = 1; mode = m[2:0]; ptr_sel = s[1:0]; disp = d[5:0]; dir_addr = da[15:0];
    wr = w; wdata = wd;
    #1;
    if (bd) begin
      chk("R11 mode_err", mode_err, 1); chk("R11 done", done, 1);
      chk("R11 busy", busy, 0); chk("R11 ptr_we", ptr_we, 0);
      chk("R11 writes", {rf_we, io_we}, 0); chk("R11 rdata", rdata, 0);
    end else if (reg_n != 2) begin
      chk({tg, " ea"}, ea, e);
      chk("R7 busy", busy, 0); chk("R7 done", done, 1);
      chk("R7 rf_we", rf_we, (reg_n == 0) && w); chk("R7 io_we", io_we, (reg_n == 1) && w);
      chk("R10 range_err", range_err, reg_n == 3);
      chk("R9 ptr_we", ptr_we, up);
      if (up) begin chk({tg, " wb value"}, ptr_wdata, nv); chk("R9 wsel", ptr_wsel, s); end
      if (!w) begin
        if (reg_n == 0) chk("R1 rf read", rdata, (e & 31) ^ 8'h5A);
        else if (reg_n == 1) chk("R1 io read", rdata, ((e - 32) + 8'h40) & 8'hFF);
        else chk("R10 rdata", rdata, 0);
      end else if (reg_n != 3) chk("R1 wdata", mem_wdata, wd);
    end else begin
      chk({tg, " ea"}, ea, e);
      chk("R8 busy", busy, 1); chk("R8 done", done, 0);
      chk("R9 no early wb", ptr_we, 0); chk("R8 sram_en early", sram_en, 0);
      @(negedge clk);
      if (hold) begin
        mode = 0; dir_addr = 16'h0003; wr = 1; wdata = 8'hEE;
      end else req = 0;
      #1;
      chk("R8 sram_en", sram_en, 1); chk("R8 sram_we", sram_we, w);
      chk("R1 sram_addr", sram_addr, e - 96); chk("R8 done", done, 1);
      chk("R9 ptr_we", ptr_we, up);
      if (up) begin chk({tg, " wb value"}, ptr_wdata, nv); chk("R9 wsel", ptr_wsel, s); end
      if (hold) begin
        chk("R12 rf_we", rf_we, 0); chk("R12 busy", busy, 0);
        chk("R12 errors", {range_err, mode_err}, 0);
      end
      if (w) begin chk("R8 wdata", mem_wdata, wd); ref_mem[e - 96] = wd; end
      else chk("R8 sram read", rdata, ref_mem[e - 96]);
    end
    if (up) begin
      if (s == 0) ptr_x = nv[15:0]; else if (s == 1) ptr_y = nv[15:0]; else ptr_z = nv[15:0];
    end
    @(negedge clk);
    req = 0; wr = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'((i * 7) + 3);
      ref_mem[i] = 8'((i * 7) + 3);
    end
    #(PERIOD * 2);
    chk("R8 reset busy", busy, 0); chk("R9 reset ptr_we", ptr_we, 0);
    chk("R8 reset sram_en", sram_en, 0); chk("R7 reset done", done, 0);
    @(negedge clk); rst_n = 1;
    for (int a = 0; a < 16'h0470; a++) access(0, 0, 0, a, 0, 0, 0);
    access(0, 0, 0, 16'hFFFF, 0, 0, 0);
    access(0, 0, 0, 16'h0470, 1, 8'h11, 0);
    for (int a = 0; a < 1024; a += 97) access(0, 0, 0, a + 96, 1, 8'(a ^ 8'hC3), 0);
    for (int a = 0; a < 1024; a += 97) access(0, 0, 0, a + 96, 0, 0, 0);
    access(0, 0, 0, 16'h0005, 1, 8'h21, 0);
    access(0, 0, 0, 16'h0045, 1, 8'h22, 0);
    ptr_x = 16'h0010; ptr_y = 16'h0030; ptr_z = 16'h0100;
    for (int s = 0; s < 3; s++) begin
      access(1, s, 0, 0, 0, 0, 0);
      access(1, s, 0, 0, 1, 8'h5C, 0);
    end
    for (int s = 1; s < 3; s++)
      for (int d = 0; d < 64; d++) access(2, s, d, 0, d[0], 8'(d), 0);
    ptr_z = 16'hFFF0;
    access(2, 2, 63, 0, 0, 0, 0);
    access(2, 0, 5, 0, 0, 0, 0);
    ptr_x = 16'h0063;
    for (int k = 0; k < 6; k++) access(3, 0, 0, 0, k[0], 8'(k + 1), 0);
    ptr_z = 16'h0000;
    access(3, 2, 0, 0, 1, 8'h77, 0);
    ptr_y = 16'h045D;
    for (int k = 0; k < 4; k++) access(4, 1, 0, 0, 0, 0, 0);
    ptr_y = 16'h001E;
    for (int k = 0; k < 4; k++) access(4, 1, 0, 0, 1, 8'(k + 8'h90), 0);
    ptr_y = 16'hFFFF;
    access(4, 1, 0, 0, 0, 0, 0);
    for (int m = 5; m < 8; m++) access(m, 1, 0, 16'h0070, 1, 8'h33, 0);
    for (int m = 1; m < 5; m++) access(m, 3, 0, 0, 1, 8'h34, 0);
    ptr_z = 16'h0200;
    access(4, 2, 0, 0, 1, 8'hAB, 1);
    access(3, 2, 0, 0, 0, 0, 1);
    access(0, 0, 0, 16'h0003, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule